// File: doc/BRIEF.md
# Test Cell PRBS Checker

This block sits on a received ATM cell stream that arrives one byte per valid cycle, with a start flag on the first byte of each 53-byte cell. It picks out diagnostic cells by comparing their four leading header bytes against a programmed pattern. It runs a local pseudo-random generator that follows the payload of those cells and reports bit errors in the payload once it has locked to the sequence. The fifth byte, the header check byte, takes no part in the match.

The local generator follows the polynomial x^15 + x^14 + 1, with bits taken MSB first within each byte. Acquisition starts by loading raw payload bytes into the generator. It then needs a clean run of predicted bytes before it declares lock. While locked, every payload byte is compared with the prediction, and the number of differing bits is added into a saturating accumulator. Reading the accumulator clears it. Too many errored bytes inside a fixed window drop the lock, and acquisition starts again. The whole function is held idle while the enable input is low.

Top module: `atmTestCellChecker`

## Requirements
- R1: After reset, `prbsLock` is 0 and `errAccum` is 0.
- R2: A cell is a test cell only if bytes 0..3 equal `hdrPattern[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order. Any other cell is ignored: it changes neither the lock, the accumulator nor the generator position.
- R3: Byte 4 of a cell (the header check byte) is never compared. Bytes 5..52 are the payload.
- R4: In acquisition, the first two payload bytes are loaded into the generator, so its state becomes the last 15 bits received. Lock then asserts in the cycle after the 16th consecutive correctly predicted byte, which is the 18th payload byte. An errored byte during that run restarts loading.
- R5: No bit error is added to `errAccum` while `prbsLock` is 0.
- R6: While locked, each payload byte adds the population count of (received XOR expected). The count saturates at 2^ACC_W-1.
- R7: A cycle with `rdAccum` high clears `errAccum`. The bit errors of a payload byte in that same cycle are kept as the new value.
- R8: Lock is lost in the cycle after the 8th errored byte within one window. Windows are consecutive blocks of 64 locked payload bytes, starting with the first byte after lock. Errored bytes split across two windows do not drop the lock.
- R9: With `enable` low, `prbsLock` is 0 from the next cycle, no payload byte is processed, and `errAccum` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Test function enable |
| hdrPattern | input | 32 | Programmed four-byte test header, first byte in the top bits |
| cellByte | input | 8 | Received cell byte |
| cellValid | input | 1 | `cellByte` is valid this cycle |
| cellStart | input | 1 | `cellByte` is byte 0 of a cell |
| rdAccum | input | 1 | Read strobe for the error accumulator (clear on read) |
| prbsLock | output | 1 | Generator locked to the payload |
| errAccum | output | 16 | Accumulated payload bit errors |

## Verification
The bench feeds cells with a single corrupted header byte at each of the four positions. A design that skipped a byte, or advanced its generator on ignored cells, would report errors on the next good cell. The bench sweeps every nonzero error mask so that the accumulator both adds population counts and reaches saturation; a wrapping counter would read near zero. It times the lock edge to the exact payload byte, both on a clean run and after an errored byte in the verify run. It splits errored bytes across a window boundary, where a sliding or unreset count would drop lock too early. It also places an errored byte in the same cycle as a read, which catches a clear that throws that byte away.

// File: rtl/atmTcPkg.sv
package atmTcPkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } lockStateT;

  typedef struct packed {
    logic loadByte;
    logic checkByte;
    logic accumEn;
  } dpStrobeT;

endpackage

// File: rtl/atmTcDatapath.sv
module atmTcDatapath
  import atmTcPkg::*;
#(
  parameter int PRBS_LEN = 15,
  parameter int PRBS_TAP = 14,
  parameter int ACC_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       cellByte,
  input  dpStrobeT         strb,
  input  logic             rdAccum,
  output logic             byteErr,
  output logic [ACC_W-1:0] errAccum
);

  localparam logic [ACC_W:0] ACC_MAX = {1'b0, {ACC_W{1'b1}}};

  logic [PRBS_LEN-1:0] lfsr;
  logic [PRBS_LEN-1:0] advState;
  logic [7:0]          expByte;
  logic [7:0]          diff;
  logic [3:0]          errBits;
  logic [ACC_W:0]      accSum;

  always_comb begin
    logic [PRBS_LEN-1:0] t;
    logic                b;
    t = lfsr;
    expByte = '0;
    for (int i = 0; i < 8; i++) begin
      b = t[PRBS_LEN-1] ^ t[PRBS_TAP-1];
      expByte[7-i] = b;
      t = {t[PRBS_LEN-2:0], b};
    end
    advState = t;
  end

  always_comb begin
    diff = strb.checkByte ? (expByte ^ cellByte) : 8'h00;
    byteErr = |diff;
    errBits = '0;
    for (int i = 0; i < 8; i++) errBits = errBits + {3'b000, diff[i]};
  end

  always_comb begin
    accSum = rdAccum ? '0 : {1'b0, errAccum};
    if (strb.accumEn) accSum = accSum + {{(ACC_W-3){1'b0}}, errBits};
    if (accSum > ACC_MAX) accSum = ACC_MAX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr     <= '0;
      errAccum <= '0;
    end else begin
      if (strb.loadByte)       lfsr <= {lfsr[PRBS_LEN-9:0], cellByte};
      else if (strb.checkByte) lfsr <= advState;
      errAccum <= accSum[ACC_W-1:0];
    end
  end

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accumEn && !rdAccum) |=> $stable(errAccum));

  a_r6_saturated_stays: assert property (@(posedge clk) disable iff (!rstN)
    (&errAccum && !rdAccum) |=> &errAccum);

  a_r7_read_leaves_one_byte: assert property (@(posedge clk) disable iff (!rstN)
    rdAccum |=> (errAccum <= ACC_W'(8)));

endmodule

// File: rtl/atmTcCtrl.sv
module atmTcCtrl
  import atmTcPkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4,
  parameter int PAY_START  = 5,
  parameter int PRBS_LEN   = 15,
  parameter int GOOD_RUN   = 16,
  parameter int LOSS_BYTES = 8,
  parameter int WIN_BYTES  = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [8*HDR_BYTES-1:0] hdrPattern,
  input  logic [7:0]             cellByte,
  input  logic                   cellValid,
  input  logic                   cellStart,
  input  logic                   byteErr,
  output dpStrobeT               strb,
  output logic                   prbsLock
);

  localparam int POS_W      = $clog2(CELL_BYTES + 1);
  localparam int LOAD_BYTES = (PRBS_LEN + 7) / 8;
  localparam int LOAD_W     = $clog2(LOAD_BYTES + 1);
  localparam int GOOD_W     = $clog2(GOOD_RUN + 1);
  localparam int BAD_W      = $clog2(LOSS_BYTES + 1);
  localparam int WIN_W      = $clog2(WIN_BYTES + 1);

  logic [POS_W-1:0]  pos, curIdx;
  logic [7:0]        hdrExp;
  logic              hdrOk, hdrByteOk, matchNow, isPayload;
  lockStateT         state;
  logic [LOAD_W-1:0] loadCnt;
  logic [GOOD_W-1:0] goodCnt;
  logic [BAD_W-1:0]  badCnt;
  logic [WIN_W-1:0]  winCnt;

  // cell position and header match
  always_comb begin
    curIdx = cellStart ? '0 : pos;
    hdrExp = '0;
    for (int i = 0; i < HDR_BYTES; i++)
      if (curIdx == POS_W'(i)) hdrExp = hdrPattern[8*(HDR_BYTES-1-i) +: 8];
    hdrByteOk = (cellByte == hdrExp);
    if (cellStart)                        matchNow = hdrByteOk;
    else if (curIdx < POS_W'(HDR_BYTES))  matchNow = hdrOk && hdrByteOk;
    else                                  matchNow = hdrOk;
    isPayload = enable && cellValid && !cellStart && hdrOk &&
                (curIdx >= POS_W'(PAY_START)) && (curIdx < POS_W'(CELL_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos   <= POS_W'(CELL_BYTES);
      hdrOk <= 1'b0;
    end else if (cellValid) begin
      pos   <= (curIdx < POS_W'(CELL_BYTES)) ? curIdx + 1'b1 : POS_W'(CELL_BYTES);
      hdrOk <= matchNow;
    end
  end

  // strobes to the datapath
  always_comb begin
    strb.loadByte  = isPayload && (state == ST_HUNT);
    strb.checkByte = isPayload && (state != ST_HUNT);
    strb.accumEn   = isPayload && (state == ST_LOCKED);
  end

  assign prbsLock = (state == ST_LOCKED);

  // lock state machine
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      state   <= ST_HUNT;
      loadCnt <= '0;
      goodCnt <= '0;
      badCnt  <= '0;
      winCnt  <= '0;
    end else if (isPayload) begin
      unique case (state)
        ST_HUNT: begin
          if (loadCnt == LOAD_W'(LOAD_BYTES - 1)) begin
            state   <= ST_VERIFY;
            loadCnt <= '0;
            goodCnt <= '0;
          end else begin
            loadCnt <= loadCnt + 1'b1;
          end
        end
        ST_VERIFY: begin
          if (byteErr) begin
            state   <= ST_HUNT;
            loadCnt <= '0;
          end else if (goodCnt == GOOD_W'(GOOD_RUN - 1)) begin
            state  <= ST_LOCKED;
            badCnt <= '0;
            winCnt <= '0;
          end else begin
            goodCnt <= goodCnt + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (byteErr && badCnt == BAD_W'(LOSS_BYTES - 1)) begin
            state   <= ST_HUNT;
            loadCnt <= '0;
          end else if (winCnt == WIN_W'(WIN_BYTES - 1)) begin
            winCnt <= '0;
            badCnt <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
            badCnt <= badCnt + {{(BAD_W-1){1'b0}}, byteErr};
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  a_r9_disable_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !prbsLock);

  a_r4_lock_after_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prbsLock) |-> $past(state == ST_VERIFY && goodCnt == GOOD_W'(GOOD_RUN - 1)
                              && strb.checkByte && !byteErr));

  a_r8_bad_below_limit: assert property (@(posedge clk) disable iff (!rstN)
    prbsLock |-> (badCnt < BAD_W'(LOSS_BYTES)));

  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadByte, strb.checkByte}));

endmodule

// File: rtl/atmTestCellChecker.sv
module atmTestCellChecker
  import atmTcPkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4,
  parameter int PAY_START  = 5,
  parameter int PRBS_LEN   = 15,
  parameter int PRBS_TAP   = 14,
  parameter int GOOD_RUN   = 16,
  parameter int LOSS_BYTES = 8,
  parameter int WIN_BYTES  = 64,
  parameter int ACC_W      = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic [8*HDR_BYTES-1:0] hdrPattern,
  input  logic [7:0]             cellByte,
  input  logic                   cellValid,
  input  logic                   cellStart,
  input  logic                   rdAccum,
  output logic                   prbsLock,
  output logic [ACC_W-1:0]       errAccum
);

  dpStrobeT strb;
  logic     byteErr;

  atmTcCtrl #(
    .CELL_BYTES(CELL_BYTES), .HDR_BYTES(HDR_BYTES), .PAY_START(PAY_START),
    .PRBS_LEN(PRBS_LEN), .GOOD_RUN(GOOD_RUN), .LOSS_BYTES(LOSS_BYTES),
    .WIN_BYTES(WIN_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .hdrPattern(hdrPattern),
    .cellByte(cellByte), .cellValid(cellValid), .cellStart(cellStart),
    .byteErr(byteErr), .strb(strb), .prbsLock(prbsLock)
  );

  atmTcDatapath #(
    .PRBS_LEN(PRBS_LEN), .PRBS_TAP(PRBS_TAP), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cellByte(cellByte), .strb(strb),
    .rdAccum(rdAccum), .byteErr(byteErr), .errAccum(errAccum)
  );

endmodule

// File: tb/atmTestCellChecker_bench.sv
module atmTestCellChecker_bench;

  localparam int ACC_W   = 10;
  localparam int ACC_MAX = (1 << ACC_W) - 1;
  localparam logic [31:0] HDR = 32'h0012_34A7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rstN, enable, cellValid, cellStart, rdAccum, prbsLock;
  logic [31:0]      hdrPattern;
  logic [7:0]       cellByte;
  logic [ACC_W-1:0] errAccum;

  atmTestCellChecker #(.ACC_W(ACC_W)) u_atmTestCellChecker (
    .clk(clk), .rstN(rstN), .enable(enable), .hdrPattern(hdrPattern),
    .cellByte(cellByte), .cellValid(cellValid), .cellStart(cellStart),
    .rdAccum(rdAccum), .prbsLock(prbsLock), .errAccum(errAccum)
  );

  int nTests = 0, nFail = 0;
  logic [14:0] gen = 15'h1234;
  int curPay = 48;
  int hecCnt = 0;
  int expAcc;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  // reference sequence: b[n] = b[n-15] ^ b[n-14], MSB first in each byte
  task automatic nextPrbs(output logic [7:0] o);
    logic b;
    o = '0;
    for (int i = 0; i < 8; i++) begin
      b = gen[14] ^ gen[13];
      o = {o[6:0], b};
      gen = {gen[13:0], b};
    end
  endtask

  task automatic drive(input logic s, input logic [7:0] b, input logic rd);
    @(negedge clk);
    cellValid = 1'b1; cellStart = s; cellByte = b; rdAccum = rd;
    @(negedge clk);
    cellValid = 1'b0; cellStart = 1'b0; rdAccum = 1'b0;
  endtask

  task automatic startCell(input logic [31:0] h);
    drive(1'b1, h[31:24], 1'b0);
    drive(1'b0, h[23:16], 1'b0);
    drive(1'b0, h[15:8], 1'b0);
    drive(1'b0, h[7:0], 1'b0);
    drive(1'b0, 8'(hecCnt * 37 + 11), 1'b0);   // R3: check byte varies freely
    hecCnt++;
    curPay = 0;
  endtask

  task automatic payByte(input logic [7:0] flip, input logic rd);
    logic [7:0] b;
    if (curPay >= 48) startCell(HDR);
    nextPrbs(b);
    drive(1'b0, b ^ flip, rd);
    curPay++;
  endtask

  task automatic rawCell(input logic [31:0] h, input logic [7:0] fill);
    startCell(h);
    for (int i = 0; i < 48; i++) drive(1'b0, fill, 1'b0);
    curPay = 48;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b1; hdrPattern = HDR;
    cellValid = 1'b0; cellStart = 1'b0; cellByte = '0; rdAccum = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 lock after reset", int'(prbsLock), 0);
    chk("R1 accum after reset", int'(errAccum), 0);

    // R4: load 2, 5 good, one errored byte restarts acquisition
    for (int i = 0; i < 7; i++) payByte(8'h00, 1'b0);
    payByte(8'h01, 1'b0);
    chk("R4 no lock after early error", int'(prbsLock), 0);
    for (int i = 0; i < 17; i++) payByte(8'h00, 1'b0);
    chk("R4 lock not before 18th byte", int'(prbsLock), 0);
    payByte(8'h00, 1'b0);
    chk("R4 lock on 18th byte", int'(prbsLock), 1);
    chk("R5 nothing counted in acquisition", int'(errAccum), 0);

    // R2: each header byte position corrupted in turn
    for (int k = 0; k < 4; k++) begin
      rawCell(HDR ^ (32'h10 << (8 * k)), 8'h00);
      chk("R2 wrong header keeps lock", int'(prbsLock), 1);
      chk("R2 wrong header not counted", int'(errAccum), 0);
    end
    for (int i = 0; i < 48; i++) payByte(8'h00, 1'b0);
    chk("R2 generator not advanced by ignored cells", int'(errAccum), 0);
    chk("R3 check byte ignored", int'(prbsLock), 1);

    // R6: sweep every nonzero mask, one errored byte per 64
    expAcc = 0;
    for (int m = 1; m < 256; m++) begin
      payByte(8'(m), 1'b0);
      expAcc += popc(8'(m));
      chk("R6 popcount accumulate", int'(errAccum), (expAcc > ACC_MAX) ? ACC_MAX : expAcc);
      for (int i = 0; i < 63; i++) payByte(8'h00, 1'b0);
    end
    chk("R6 saturated", int'(errAccum), ACC_MAX);
    chk("R6 still locked", int'(prbsLock), 1);

    // R7: read with an errored byte in the same cycle
    payByte(8'h07, 1'b1);
    chk("R7 read keeps same-cycle errors", int'(errAccum), 3);
    payByte(8'h00, 1'b1);
    chk("R7 read clears", int'(errAccum), 0);

    // R8: realign to a window boundary by relocking
    enable = 1'b0;
    @(negedge clk);
    chk("R9 disable drops lock", int'(prbsLock), 0);
    rawCell(HDR, 8'hA5);
    chk("R9 disabled bytes ignored", int'(errAccum), 0);
    chk("R9 stays unlocked", int'(prbsLock), 0);
    enable = 1'b1;
    curPay = 48;
    for (int i = 0; i < 17; i++) payByte(8'h00, 1'b0);
    chk("R9 relock not early", int'(prbsLock), 0);
    payByte(8'h00, 1'b0);
    chk("R9 relock after enable", int'(prbsLock), 1);
    // window positions 0..59 clean, 60..67 errored (split 4 + 4)
    for (int i = 0; i < 60; i++) payByte(8'h00, 1'b0);
    for (int i = 0; i < 8; i++) payByte(8'h01, 1'b0);
    chk("R8 split burst keeps lock", int'(prbsLock), 1);
    for (int i = 68; i < 128; i++) payByte(8'h00, 1'b0);
    for (int i = 0; i < 7; i++) payByte(8'h01, 1'b0);
    chk("R8 seven errored bytes keep lock", int'(prbsLock), 1);
    payByte(8'h01, 1'b0);
    chk("R8 eighth errored byte drops lock", int'(prbsLock), 0);
    chk("R8 errors counted up to loss", int'(errAccum), 16);
    for (int i = 0; i < 9; i++) payByte(8'hFF, 1'b0);
    chk("R5 no count while unlocked", int'(errAccum), 16);
    chk("R5 not relocked on bad data", int'(prbsLock), 0);
    for (int i = 0; i < 17; i++) payByte(8'h00, 1'b0);
    chk("R4 reacquire not early", int'(prbsLock), 0);
    payByte(8'h00, 1'b0);
    chk("R4 reacquire on 18th byte", int'(prbsLock), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule